// File: doc/BRIEF.md
# Dual Accumulator Register Unit

This block is the register state and small arithmetic path for a processor core of the 8-bit accumulator family. It holds two 8-bit accumulators, A and B, and two 16-bit index registers, X and Y. It also holds an 8-bit flag register. A and B, read together with A in the high byte, act as one 16-bit value D. An instruction sequencer presents an operation code and a 16-bit immediate, then raises `start_i` for one cycle. The state is written on that clock edge, and `done_o` is high during the following cycle. All registers can be read at any time.

Several operations are deliberately one-sided. Only B can be added to an index register. Only A moves to and from the flag register. Only A can be decimal-adjusted. The two-accumulator add, subtract and compare always take A as the left operand. D can be exchanged whole with either index register. Memory operands, the stack and instruction decode belong to other blocks.

Top module: `dacc_unit`

## Requirements
- R1: Reset (`rst_n` low) clears A, B, X and Y. It sets the flag register to 0xD0 and holds `done_o` low. Flag bits, from bit 7 down to bit 0, are S, X-mask, H, I, N, Z, V, C.
- R2: Operation codes are: 0 no-op, 1 load A, 2 load B, 3 load X, 4 load Y, 5 A+B into A, 6 A-B into A, 7 compare A with B, 8 add B to X, 9 add B to Y, 10 A into flags, 11 flags into A, 12 decimal adjust A, 13 swap D and X, 14 swap D and Y. An operation whose code is presented with `start_i` high takes effect on that clock edge. `done_o` is high exactly in each cycle that follows a cycle with `start_i` high. `d_o` always equals A in the high byte and B in the low byte.
- R3: Load A and load B take `imm_i[7:0]`. They set N from bit 7 and Z when the value is zero, clear V, and leave H and C unchanged. Load X and load Y take all 16 bits of `imm_i` and leave the flags unchanged.
- R4: A+B writes the 8-bit sum to A. It sets H to the carry out of bit 3 and C to the carry out of bit 7. N and Z follow the result. V is set when A and B share a sign that the result does not have.
- R5: A-B writes the 8-bit difference to A. C is set when B is greater than A as unsigned numbers. V is set when A and B differ in sign and the result's sign differs from A. N and Z follow the result, and H is unchanged.
- R6: Compare sets N, Z, V and C exactly as A-B would, and leaves A, B and H unchanged.
- R7: Add B to X or Y zero-extends B, wraps modulo 65536, and changes no flag.
- R8: Flags into A copies the flag register into A and changes no flag.
- R9: A into flags loads every flag bit from A, except that the X-mask bit (bit 6) becomes the logical AND of its old value and A bit 6, so it can be cleared but never set.
- R10: Decimal adjust adds 0x06 when H is set or the low nibble exceeds 9. It adds 0x60 when C is set, when the high nibble exceeds 9, or when the high nibble is at least 9 and the low nibble exceeds 9. C becomes 1 when the 0x60 correction applies and is otherwise unchanged. N and Z follow the result, and H and V are unchanged.
- R11: Swap D with X (or Y) exchanges the full 16-bit values in one step and changes no flag.
- R12: With `start_i` low, or with the no-op code, no register changes, whatever `op_i` and `imm_i` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Execute the operation on `op_i` at this edge |
| op_i | input | 4 | Operation code (see R2) |
| imm_i | input | 16 | Immediate value for the load operations |
| done_o | output | 1 | High in the cycle after an accepted operation |
| a_o | output | 8 | Accumulator A |
| b_o | output | 8 | Accumulator B |
| d_o | output | 16 | Double accumulator, A high and B low |
| x_o | output | 16 | Index register X |
| y_o | output | 16 | Index register Y |
| ccr_o | output | 8 | Flag register |

## Verification
When `start_i` stays high, the completion pulse of one operation falls in the same cycle as the acceptance of the next. The next operation must then read state that was written only one edge earlier. The bench provokes this by issuing a swap of D and X immediately followed by an add of B to X. It judges the result by requiring that `done_o` stays high across both cycles and that the add uses the B and X left by the swap rather than the older values. The vector table is also issued without gaps, so every table step repeats this overlap with a different pair of operations.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

  localparam int ACC_W = 8;
  localparam int DBL_W = 2 * ACC_W;
  localparam int NIB_W = 4;
  localparam int OP_W  = 4;

  localparam int CC_S = 7;
  localparam int CC_X = 6;
  localparam int CC_H = 5;
  localparam int CC_I = 4;
  localparam int CC_N = 3;
  localparam int CC_Z = 2;
  localparam int CC_V = 1;
  localparam int CC_C = 0;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'd0,
    OP_LDA  = 4'd1,
    OP_LDB  = 4'd2,
    OP_LDX  = 4'd3,
    OP_LDY  = 4'd4,
    OP_ABA  = 4'd5,
    OP_SBA  = 4'd6,
    OP_CBA  = 4'd7,
    OP_ABX  = 4'd8,
    OP_ABY  = 4'd9,
    OP_TAP  = 4'd10,
    OP_TPA  = 4'd11,
    OP_DAA  = 4'd12,
    OP_XGDX = 4'd13,
    OP_XGDY = 4'd14
  } op_e;

  // Result byte plus the five arithmetic flags an operation may produce.
  typedef struct packed {
    logic [ACC_W-1:0] res;
    logic             h;
    logic             n;
    logic             z;
    logic             v;
    logic             c;
  } flag_res_t;

  // Value moved without arithmetic: N/Z from value, V cleared, H/C kept.
  function automatic flag_res_t acc_pass(input logic [ACC_W-1:0] x,
                                         input logic h_in, input logic c_in);
    flag_res_t r;
    r.res = x;
    r.h   = h_in;
    r.n   = x[ACC_W-1];
    r.z   = (x == '0);
    r.v   = 1'b0;
    r.c   = c_in;
    return r;
  endfunction

  function automatic flag_res_t acc_add(input logic [ACC_W-1:0] x,
                                        input logic [ACC_W-1:0] y);
    flag_res_t r;
    logic [ACC_W:0] full;
    logic [NIB_W:0] low;
    full  = {1'b0, x} + {1'b0, y};
    low   = {1'b0, x[NIB_W-1:0]} + {1'b0, y[NIB_W-1:0]};
    r.res = full[ACC_W-1:0];
    r.h   = low[NIB_W];
    r.n   = r.res[ACC_W-1];
    r.z   = (r.res == '0);
    r.v   = (x[ACC_W-1] == y[ACC_W-1]) && (r.res[ACC_W-1] != x[ACC_W-1]);
    r.c   = full[ACC_W];
    return r;
  endfunction

  function automatic flag_res_t acc_sub(input logic [ACC_W-1:0] x,
                                        input logic [ACC_W-1:0] y,
                                        input logic h_in);
    flag_res_t r;
    logic [ACC_W:0] full;
    full  = {1'b0, x} - {1'b0, y};
    r.res = full[ACC_W-1:0];
    r.h   = h_in;
    r.n   = r.res[ACC_W-1];
    r.z   = (r.res == '0);
    r.v   = (x[ACC_W-1] != y[ACC_W-1]) && (r.res[ACC_W-1] != x[ACC_W-1]);
    r.c   = full[ACC_W];
    return r;
  endfunction

  function automatic flag_res_t acc_daa(input logic [ACC_W-1:0] x,
                                        input logic h_in, input logic v_in,
                                        input logic c_in);
    flag_res_t r;
    logic [NIB_W-1:0] lo;
    logic [ACC_W-NIB_W-1:0] hi;
    logic lo_fix;
    logic hi_fix;
    logic [ACC_W-1:0] corr;
    lo     = x[NIB_W-1:0];
    hi     = x[ACC_W-1:NIB_W];
    lo_fix = h_in || (lo > 4'd9);
    hi_fix = c_in || (hi > 4'd9) || ((hi >= 4'd9) && (lo > 4'd9));
    corr   = {(hi_fix ? 4'h6 : 4'h0), (lo_fix ? 4'h6 : 4'h0)};
    r.res  = x + corr;
    r.h    = h_in;
    r.n    = r.res[ACC_W-1];
    r.z    = (r.res == '0);
    r.v    = v_in;
    r.c    = hi_fix;
    return r;
  endfunction

  // Replace H, N, Z, V, C in a flag byte; S, X-mask and I are kept.
  function automatic logic [ACC_W-1:0] cc_merge(input logic [ACC_W-1:0] cc,
                                                input flag_res_t r);
    logic [ACC_W-1:0] o;
    o       = cc;
    o[CC_H] = r.h;
    o[CC_N] = r.n;
    o[CC_Z] = r.z;
    o[CC_V] = r.v;
    o[CC_C] = r.c;
    return o;
  endfunction

endpackage

// File: rtl/dacc_alu8.sv
module dacc_alu8
  import dacc_pkg::*;
(
  input  op_e              op_i,
  input  logic [ACC_W-1:0] a_i,
  input  logic [ACC_W-1:0] b_i,
  input  logic [ACC_W-1:0] cc_i,
  input  logic [ACC_W-1:0] imm_i,
  output logic [ACC_W-1:0] a_o,
  output logic [ACC_W-1:0] b_o,
  output logic [ACC_W-1:0] cc_o
);

  flag_res_t add_r;
  flag_res_t sub_r;
  flag_res_t daa_r;
  flag_res_t lda_r;
  flag_res_t ldb_r;

  assign add_r = acc_add(a_i, b_i);
  assign sub_r = acc_sub(a_i, b_i, cc_i[CC_H]);
  assign daa_r = acc_daa(a_i, cc_i[CC_H], cc_i[CC_V], cc_i[CC_C]);
  assign lda_r = acc_pass(imm_i, cc_i[CC_H], cc_i[CC_C]);
  assign ldb_r = acc_pass(imm_i, cc_i[CC_H], cc_i[CC_C]);

  always_comb begin
    a_o  = a_i;
    b_o  = b_i;
    cc_o = cc_i;
    case (op_i)
      OP_LDA: begin
        a_o  = lda_r.res;
        cc_o = cc_merge(cc_i, lda_r);
      end
      OP_LDB: begin
        b_o  = ldb_r.res;
        cc_o = cc_merge(cc_i, ldb_r);
      end
      OP_ABA: begin
        a_o  = add_r.res;
        cc_o = cc_merge(cc_i, add_r);
      end
      OP_SBA: begin
        a_o  = sub_r.res;
        cc_o = cc_merge(cc_i, sub_r);
      end
      OP_CBA: begin
        cc_o = cc_merge(cc_i, sub_r);
      end
      OP_DAA: begin
        a_o  = daa_r.res;
        cc_o = cc_merge(cc_i, daa_r);
      end
      OP_TPA: begin
        a_o = cc_i;
      end
      OP_TAP: begin
        cc_o       = a_i;
        cc_o[CC_X] = cc_i[CC_X] & a_i[CC_X];
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/dacc_idx_reg.sv
module dacc_idx_reg
  import dacc_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  op_e              op_i,
  input  logic [DBL_W-1:0] imm_i,
  input  logic [DBL_W-1:0] d_i,
  input  logic [ACC_W-1:0] b_i,
  output logic [DBL_W-1:0] val_o,
  output logic             swap_o
);

  localparam op_e LD_OP  = (SLOT == 0) ? OP_LDX  : OP_LDY;
  localparam op_e ADD_OP = (SLOT == 0) ? OP_ABX  : OP_ABY;
  localparam op_e SWP_OP = (SLOT == 0) ? OP_XGDX : OP_XGDY;
  localparam int  PAD_W  = DBL_W - ACC_W;

  logic             ld_hit;
  logic             add_hit;
  logic             swp_hit;
  logic [DBL_W-1:0] b_wide;
  logic [DBL_W-1:0] val_q;

  assign ld_hit  = start_i && (op_i == LD_OP);
  assign add_hit = start_i && (op_i == ADD_OP);
  assign swp_hit = start_i && (op_i == SWP_OP);
  assign b_wide  = {{PAD_W{1'b0}}, b_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (ld_hit) begin
      val_q <= imm_i;
    end else if (add_hit) begin
      val_q <= val_q + b_wide;
    end else if (swp_hit) begin
      val_q <= d_i;
    end
  end

  assign val_o  = val_q;
  assign swap_o = swp_hit;

  AST_SWAP_TAKES_D: assert property (@(posedge clk) disable iff (!rst_n)
    swp_hit |=> (val_o == $past(d_i))); // R11

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit || add_hit || swp_hit) |=> $stable(val_o)); // R12

endmodule

// File: rtl/dacc_unit.sv
module dacc_unit
  import dacc_pkg::*;
#(
  parameter logic [ACC_W-1:0] CCR_RESET = 8'hD0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [DBL_W-1:0] imm_i,
  output logic             done_o,
  output logic [ACC_W-1:0] a_o,
  output logic [ACC_W-1:0] b_o,
  output logic [DBL_W-1:0] d_o,
  output logic [DBL_W-1:0] x_o,
  output logic [DBL_W-1:0] y_o,
  output logic [ACC_W-1:0] ccr_o
);

  localparam int NUM_IDX = 2;

  op_e              op_w;
  logic [ACC_W-1:0] a_q;
  logic [ACC_W-1:0] b_q;
  logic [ACC_W-1:0] cc_q;
  logic             done_q;
  logic [ACC_W-1:0] a_nxt;
  logic [ACC_W-1:0] b_nxt;
  logic [ACC_W-1:0] cc_nxt;
  logic [DBL_W-1:0] d_w;
  logic [DBL_W-1:0] idx_val [NUM_IDX];
  logic [NUM_IDX-1:0] swap_hit;

  assign op_w = op_e'(op_i);
  assign d_w  = {a_q, b_q};

  dacc_alu8 u_alu (
    .op_i  (op_w),
    .a_i   (a_q),
    .b_i   (b_q),
    .cc_i  (cc_q),
    .imm_i (imm_i[ACC_W-1:0]),
    .a_o   (a_nxt),
    .b_o   (b_nxt),
    .cc_o  (cc_nxt)
  );

  for (genvar gi = 0; gi < NUM_IDX; gi++) begin : g_idx
    dacc_idx_reg #(.SLOT(gi)) u_idx (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .op_i    (op_w),
      .imm_i   (imm_i),
      .d_i     (d_w),
      .b_i     (b_q),
      .val_o   (idx_val[gi]),
      .swap_o  (swap_hit[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      cc_q   <= CCR_RESET;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) begin
        if (swap_hit[0]) begin
          {a_q, b_q} <= idx_val[0];
        end else if (swap_hit[1]) begin
          {a_q, b_q} <= idx_val[1];
        end else begin
          a_q  <= a_nxt;
          b_q  <= b_nxt;
          cc_q <= cc_nxt;
        end
      end
    end
  end

  assign done_o = done_q;
  assign a_o    = a_q;
  assign b_o    = b_q;
  assign d_o    = d_w;
  assign x_o    = idx_val[0];
  assign y_o    = idx_val[1];
  assign ccr_o  = cc_q;

  AST_DONE_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o); // R2

  AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_w == OP_CBA) |=> $stable(a_o)); // R6

  AST_IDX_ADD_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (op_w == OP_ABX || op_w == OP_ABY)) |=> $stable(ccr_o)); // R7

  AST_FLAGS_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_w == OP_TPA) |=> (a_o == $past(ccr_o))); // R8

  AST_XMASK_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_w == OP_TAP && !ccr_o[CC_X]) |=> !ccr_o[CC_X]); // R9

  AST_DAA_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_w == OP_DAA && ccr_o[CC_C]) |=> ccr_o[CC_C]); // R10

  AST_SWAP_X_TO_D: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_w == OP_XGDX) |=> (d_o == $past(x_o) && x_o == $past(d_o))); // R11

endmodule

// File: tb/sim_dacc_unit.sv
module sim_dacc_unit;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  op;
  logic [15:0] imm;
  logic        done;
  logic [7:0]  a_w;
  logic [7:0]  b_w;
  logic [15:0] d_w;
  logic [15:0] x_w;
  logic [15:0] y_w;
  logic [7:0]  cc_w;

  int n_chk = 0;
  int n_err = 0;

  localparam int WDOG = 20000;
  localparam int NV   = 30;

  // {op, imm, expected A, B, X, Y, flags} after each step, issued back to back
  localparam logic [75:0] VEC [NV] = '{
    {4'd1,  16'hAB38, 8'h38, 8'h00, 16'h0000, 16'h0000, 8'hD0},
    {4'd2,  16'h0049, 8'h38, 8'h49, 16'h0000, 16'h0000, 8'hD0},
    {4'd5,  16'h0000, 8'h81, 8'h49, 16'h0000, 16'h0000, 8'hFA},
    {4'd12, 16'h0000, 8'h87, 8'h49, 16'h0000, 16'h0000, 8'hFA},
    {4'd1,  16'h0099, 8'h99, 8'h49, 16'h0000, 16'h0000, 8'hF8},
    {4'd2,  16'h0001, 8'h99, 8'h01, 16'h0000, 16'h0000, 8'hF0},
    {4'd5,  16'h0000, 8'h9A, 8'h01, 16'h0000, 16'h0000, 8'hD8},
    {4'd12, 16'h0000, 8'h00, 8'h01, 16'h0000, 16'h0000, 8'hD5},
    {4'd6,  16'h0000, 8'hFF, 8'h01, 16'h0000, 16'h0000, 8'hD9},
    {4'd7,  16'h0000, 8'hFF, 8'h01, 16'h0000, 16'h0000, 8'hD8},
    {4'd1,  16'h0080, 8'h80, 8'h01, 16'h0000, 16'h0000, 8'hD8},
    {4'd2,  16'h0001, 8'h80, 8'h01, 16'h0000, 16'h0000, 8'hD0},
    {4'd6,  16'h0000, 8'h7F, 8'h01, 16'h0000, 16'h0000, 8'hD2},
    {4'd7,  16'h0000, 8'h7F, 8'h01, 16'h0000, 16'h0000, 8'hD0},
    {4'd2,  16'h007F, 8'h7F, 8'h7F, 16'h0000, 16'h0000, 8'hD0},
    {4'd7,  16'h0000, 8'h7F, 8'h7F, 16'h0000, 16'h0000, 8'hD4},
    {4'd11, 16'h0000, 8'hD4, 8'h7F, 16'h0000, 16'h0000, 8'hD4},
    {4'd1,  16'h000F, 8'h0F, 8'h7F, 16'h0000, 16'h0000, 8'hD0},
    {4'd10, 16'h0000, 8'h0F, 8'h7F, 16'h0000, 16'h0000, 8'h0F},
    {4'd1,  16'h00FF, 8'hFF, 8'h7F, 16'h0000, 16'h0000, 8'h09},
    {4'd10, 16'h0000, 8'hFF, 8'h7F, 16'h0000, 16'h0000, 8'hBF},
    {4'd11, 16'h0000, 8'hBF, 8'h7F, 16'h0000, 16'h0000, 8'hBF},
    {4'd3,  16'hFFF0, 8'hBF, 8'h7F, 16'hFFF0, 16'h0000, 8'hBF},
    {4'd8,  16'h0000, 8'hBF, 8'h7F, 16'h006F, 16'h0000, 8'hBF},
    {4'd4,  16'h1234, 8'hBF, 8'h7F, 16'h006F, 16'h1234, 8'hBF},
    {4'd9,  16'h0000, 8'hBF, 8'h7F, 16'h006F, 16'h12B3, 8'hBF},
    {4'd13, 16'h0000, 8'h00, 8'h6F, 16'hBF7F, 16'h12B3, 8'hBF},
    {4'd14, 16'h0000, 8'h12, 8'hB3, 16'hBF7F, 16'h006F, 8'hBF},
    {4'd0,  16'hFFFF, 8'h12, 8'hB3, 16'hBF7F, 16'h006F, 8'hBF},
    {4'd8,  16'h0000, 8'h12, 8'hB3, 16'hC032, 16'h006F, 8'hBF}
  };

  dacc_unit u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .op_i    (op),
    .imm_i   (imm),
    .done_o  (done),
    .a_o     (a_w),
    .b_o     (b_w),
    .d_o     (d_w),
    .x_o     (x_w),
    .y_o     (y_w),
    .ccr_o   (cc_w)
  );

  always #2 clk = ~clk;

  function automatic string req_of(input logic [3:0] code);
    case (code)
      4'd0:                  return "R12";
      4'd1, 4'd2, 4'd3, 4'd4: return "R3";
      4'd5:                  return "R4";
      4'd6:                  return "R5";
      4'd7:                  return "R6";
      4'd8, 4'd9:            return "R7";
      4'd10:                 return "R9";
      4'd11:                 return "R8";
      4'd12:                 return "R10";
      default:               return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [7:0] ea, input logic [7:0] eb,
                           input logic [15:0] ex, input logic [15:0] ey, input logic [7:0] ec);
    chk(req, "A,B,X,Y,flags", 64'({a_w, b_w, x_w, y_w, cc_w}), 64'({ea, eb, ex, ey, ec}));
    chk("R2", "D port", 64'(d_w), 64'({ea, eb}));
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    clk   = 1'b0;
    rst_n = 1'b0;
    start = 1'b0;
    op    = 4'd0;
    imm   = 16'h0000;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk_state("R1", 8'h00, 8'h00, 16'h0000, 16'h0000, 8'hD0);
    chk("R1", "done", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: code and immediate present but no start strobe
    op  = 4'd1;
    imm = 16'hFFFF;
    repeat (2) @(negedge clk);
    chk_state("R12", 8'h00, 8'h00, 16'h0000, 16'h0000, 8'hD0);
    chk("R12", "done", 64'(done), 64'd0);

    // Table, issued without gaps
    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v     = VEC[i];
      start = 1'b1;
      op    = v[75:72];
      imm   = v[71:56];
      @(negedge clk);
      chk("R2", "done", 64'(done), 64'd1);
      chk_state(req_of(v[75:72]), v[55:48], v[47:40], v[39:24], v[23:8], v[7:0]);
    end
    start = 1'b0;
    @(negedge clk);
    chk("R2", "done after idle", 64'(done), 64'd0);

    // R11 then R7 back to back: add must see the swapped X and B
    start = 1'b1;
    op    = 4'd13;
    @(negedge clk);
    chk("R2", "done swap", 64'(done), 64'd1);
    chk_state("R11", 8'hC0, 8'h32, 16'h12B3, 16'h006F, 8'hBF);
    op = 4'd8;
    @(negedge clk);
    chk("R2", "done add overlap", 64'(done), 64'd1);
    chk_state("R7", 8'hC0, 8'h32, 16'h12E5, 16'h006F, 8'hBF);
    start = 1'b0;
    @(negedge clk);
    chk("R2", "done drop", 64'(done), 64'd0);

    // R1: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk_state("R1", 8'h00, 8'h00, 16'h0000, 16'h0000, 8'hD0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: loading zero sets Z
    start = 1'b1;
    op    = 4'd1;
    imm   = 16'h5500;
    @(negedge clk);
    start = 1'b0;
    chk_state("R3", 8'h00, 8'h00, 16'h0000, 16'h0000, 8'hD4);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule